// File: doc/BRIEF.md
# In-Order Completion Buffer

This block keeps the program order of in-flight instructions in a six-slot circular queue. A dispatcher claims one or two slots per cycle at the tail and receives the slot numbers as tags. Execution units later report, by tag, that an instruction has finished and whether it raised an exception. From the oldest end the block releases up to two finished, exception-free instructions per cycle, never out of order.

Two events cut the queue short. A mispredicted branch keeps the branch and everything older, discards everything younger, and moves the tail to the slot after the branch. An exception on the oldest entry stops retirement, reports that entry's tag, and empties the whole queue so that the exception is precise. All results leave through registers.

Top module: `cq_order_buf`

## Requirements
- R1: The queue has six slots with tags 0 to 5. `slot_tag_a` is the tail slot and `slot_tag_b` the slot after it, both wrapping from 5 to 0.
- R2: A claim of `claim_req` = 01 takes one slot and 11 takes two. It is accepted only when the number asked for does not exceed `free_slots` in that cycle, and no exception or accepted mispredict occurs in that cycle. On acceptance `free_slots` drops by that number at the next edge. A claim of 10 takes nothing.
- R3: A finish report marks an occupied slot finished, and marks it faulted when `done_fault` is set. A report naming an unoccupied slot or a tag of 6 or 7 has no effect.
- R4: The oldest entry retires only when it is finished and not faulted. `ret_valid[0]` and `ret_tag_a` appear one edge after the cycle in which the entry's finished state is held.
- R5: At most two entries retire per cycle. `ret_valid[1]` with `ret_tag_b` is used only for the entry right after the oldest, only when the oldest also retires that cycle, and only when that second entry is finished and not faulted.
- R6: When the oldest entry is finished and faulted, nothing retires. `fault_taken` pulses for one cycle with `fault_tag` equal to its tag. Every entry is discarded and `free_slots` returns to 6 at the same edge.
- R7: A `mis_valid` naming an occupied slot discards every younger entry. The tail is set to the slot after the branch, `free_slots` is updated, and `squash_young` pulses, all at the same edge. A claim in that cycle is dropped, and an entry younger than the branch does not retire in that cycle.
- R8: A `mis_valid` naming an unoccupied slot or a tag of 6 or 7 is ignored.
- R9: When an exception at the oldest entry and a valid mispredict fall in the same cycle, the exception handling of R6 applies and `squash_young` stays low.
- R10: After a synchronous reset the queue is empty: `free_slots` is 6, the tail tag is 0, and all pulses and retire valids are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| claim_req | input | 2 | Slot claim: 01 one slot, 11 two slots |
| slot_tag_a | output | 3 | Tag given to the first claimed slot |
| slot_tag_b | output | 3 | Tag given to the second claimed slot |
| free_slots | output | 3 | Number of unoccupied slots |
| done_valid | input | 2 | Finish report strobe per report port |
| done_tag | input | 6 | Finish report tags, port p in bits 3p+2..3p |
| done_fault | input | 2 | Finish report carries an exception, per port |
| mis_valid | input | 1 | Branch mispredict strobe |
| mis_tag | input | 3 | Tag of the mispredicted branch |
| ret_valid | output | 2 | Retire strobes, bit 0 oldest slot, bit 1 next slot |
| ret_tag_a | output | 3 | Tag retired in slot 0 |
| ret_tag_b | output | 3 | Tag retired in slot 1 |
| fault_taken | output | 1 | One-cycle pulse: exception at oldest entry taken |
| fault_tag | output | 3 | Tag of the faulting entry |
| squash_young | output | 1 | One-cycle pulse: younger-than-branch discard done |

## Verification
The slot count and the tail tags move at the very edge that accepts a claim, a mispredict or an exception. Retire strobes, the exception pulse and the squash pulse appear one edge after the cycle whose state caused them, so a finish report reaches a retire strobe two edges after it is presented. The bench applies inputs just after a falling edge, steps a queue-based model of the requirements once per cycle, and compares every output at the following falling edge against that step's prediction. Tags are compared only while their strobe is high.

// File: rtl/cq_order_pkg.sv
package cq_order_pkg;
  // Modular add for circular pointers; k must not exceed depth.
  function automatic int unsigned wrap_add(int unsigned p, int unsigned k,
                                           int unsigned depth);
    int unsigned s;
    s = p + k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/cq_slot_state.sv
module cq_slot_state #(
  parameter int DEPTH     = 6,
  parameter int FIN_PORTS = 2,
  parameter int TAG_W     = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [DEPTH-1:0]           alloc_mask,
  input  logic [DEPTH-1:0]           kill_mask,
  input  logic [FIN_PORTS-1:0]       fin_vld,
  input  logic [FIN_PORTS*TAG_W-1:0] fin_tag,
  input  logic [FIN_PORTS-1:0]       fin_flt,
  output logic [DEPTH-1:0]           occ_q,
  output logic [DEPTH-1:0]           done_q,
  output logic [DEPTH-1:0]           flt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= '0;
      done_q <= '0;
      flt_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_mask[i]) begin
          occ_q[i]  <= 1'b1;
          done_q[i] <= 1'b0;
          flt_q[i]  <= 1'b0;
        end else begin
          if (kill_mask[i]) occ_q[i] <= 1'b0;
          for (int p = 0; p < FIN_PORTS; p++) begin
            if (fin_vld[p] && occ_q[i] &&
                fin_tag[p*TAG_W +: TAG_W] == TAG_W'(i)) begin
              done_q[i] <= 1'b1;
              if (fin_flt[p]) flt_q[i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  // A claimed slot must be free when it is written (R2).
  assert_alloc_free_R2: assert property (@(posedge clk) disable iff (rst)
    (alloc_mask & occ_q) == '0);
endmodule

// File: rtl/cq_retire_pick.sv
module cq_retire_pick #(
  parameter int DEPTH = 6,
  parameter int TAG_W = 3
) (
  input  logic [TAG_W-1:0] head,
  input  logic [DEPTH-1:0] occ,
  input  logic [DEPTH-1:0] done,
  input  logic [DEPTH-1:0] flt,
  input  logic             br_hit,
  input  logic [TAG_W-1:0] br_off,
  output logic [TAG_W-1:0] next_idx,
  output logic             take0,
  output logic             take1,
  output logic             flt_hit
);
  import cq_order_pkg::*;

  logic head_ready;

  always_comb begin
    next_idx   = TAG_W'(wrap_add(32'(head), 1, DEPTH));
    head_ready = occ[head] && done[head];
    flt_hit    = head_ready && flt[head];
    take0      = head_ready && !flt[head];
    // Second slot only behind a retiring head, and never past a branch
    // that is being squashed behind the head this cycle.
    take1      = take0 && occ[next_idx] && done[next_idx] && !flt[next_idx] &&
                 !(br_hit && br_off == '0);
  end
endmodule

// File: rtl/cq_order_buf.sv
module cq_order_buf #(
  parameter  int DEPTH     = 6,
  parameter  int FIN_PORTS = 2,
  localparam int TAG_W     = $clog2(DEPTH),
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 claim_req,
  output logic [TAG_W-1:0]           slot_tag_a,
  output logic [TAG_W-1:0]           slot_tag_b,
  output logic [CW-1:0]              free_slots,
  input  logic [FIN_PORTS-1:0]       done_valid,
  input  logic [FIN_PORTS*TAG_W-1:0] done_tag,
  input  logic [FIN_PORTS-1:0]       done_fault,
  input  logic                       mis_valid,
  input  logic [TAG_W-1:0]           mis_tag,
  output logic [1:0]                 ret_valid,
  output logic [TAG_W-1:0]           ret_tag_a,
  output logic [TAG_W-1:0]           ret_tag_b,
  output logic                       fault_taken,
  output logic [TAG_W-1:0]           fault_tag,
  output logic                       squash_young
);
  import cq_order_pkg::*;

  logic [TAG_W-1:0] head_q, tail_q, head_n, tail_n, next_idx, br_off;
  logic [CW-1:0]    free_q, free_n;
  logic [DEPTH-1:0] occ_q, done_q, flt_q, alloc_mask, kill_mask;
  logic             take0, take1, flt_hit, br_ok, br_hit, claim_ok;
  int unsigned      n_ret, n_claim, keep;

  cq_slot_state #(.DEPTH(DEPTH), .FIN_PORTS(FIN_PORTS), .TAG_W(TAG_W)) u_state (
    .clk(clk), .rst(rst), .alloc_mask(alloc_mask), .kill_mask(kill_mask),
    .fin_vld(done_valid), .fin_tag(done_tag), .fin_flt(done_fault),
    .occ_q(occ_q), .done_q(done_q), .flt_q(flt_q));

  cq_retire_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
    .head(head_q), .occ(occ_q), .done(done_q), .flt(flt_q),
    .br_hit(br_ok), .br_off(br_off), .next_idx(next_idx),
    .take0(take0), .take1(take1), .flt_hit(flt_hit));

  assign slot_tag_a = tail_q;
  assign slot_tag_b = TAG_W'(wrap_add(32'(tail_q), 1, DEPTH));
  assign free_slots = free_q;

  always_comb begin
    br_ok    = mis_valid && (mis_tag < TAG_W'(DEPTH)) && occ_q[mis_tag];
    br_hit   = br_ok && !flt_hit;
    br_off   = TAG_W'(wrap_add(32'(mis_tag), DEPTH - 32'(head_q), DEPTH));
    n_ret    = 32'(take0) + 32'(take1);
    n_claim  = (claim_req == 2'b01) ? 1 : (claim_req == 2'b11) ? 2 : 0;
    claim_ok = (n_claim != 0) && (n_claim <= 32'(free_q)) && !flt_hit && !br_hit;
    keep     = 32'(br_off) + 1 - n_ret;

    alloc_mask = '0;
    kill_mask  = '0;
    if (take0) kill_mask[head_q]   = 1'b1;
    if (take1) kill_mask[next_idx] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (flt_hit) kill_mask[i] = 1'b1;
      if (br_hit && wrap_add(i, DEPTH - 32'(head_q), DEPTH) > 32'(br_off))
        kill_mask[i] = 1'b1;
    end
    if (claim_ok) begin
      alloc_mask[slot_tag_a] = 1'b1;
      if (n_claim == 2) alloc_mask[slot_tag_b] = 1'b1;
    end

    if (flt_hit) begin
      head_n = tail_q;
      tail_n = tail_q;
      free_n = CW'(DEPTH);
    end else begin
      head_n = TAG_W'(wrap_add(32'(head_q), n_ret, DEPTH));
      if (br_hit) begin
        tail_n = TAG_W'(wrap_add(32'(mis_tag), 1, DEPTH));
        free_n = CW'(DEPTH - keep);
      end else begin
        tail_n = TAG_W'(wrap_add(32'(tail_q), claim_ok ? n_claim : 0, DEPTH));
        free_n = CW'(32'(free_q) + n_ret - (claim_ok ? n_claim : 0));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q       <= '0;
      tail_q       <= '0;
      free_q       <= CW'(DEPTH);
      ret_valid    <= '0;
      ret_tag_a    <= '0;
      ret_tag_b    <= '0;
      fault_taken  <= 1'b0;
      fault_tag    <= '0;
      squash_young <= 1'b0;
    end else begin
      head_q       <= head_n;
      tail_q       <= tail_n;
      free_q       <= free_n;
      ret_valid    <= {take1, take0};
      ret_tag_a    <= head_q;
      ret_tag_b    <= next_idx;
      fault_taken  <= flt_hit;
      fault_tag    <= head_q;
      squash_young <= br_hit;
    end
  end

  // Occupancy held in the slot state agrees with the free count (R1).
  assert_occ_count_R1: assert property (@(posedge clk) disable iff (rst)
    ($countones(occ_q) + 32'(free_q)) == DEPTH);
  // A retired oldest entry had been finished in the cycle before (R4).
  assert_retire_done_R4: assert property (@(posedge clk) disable iff (rst)
    ret_valid[0] |-> $past(done_q[head_q] && !flt_q[head_q]));
  // No retirement alongside a taken exception; queue emptied (R6).
  assert_fault_stop_R6: assert property (@(posedge clk) disable iff (rst)
    fault_taken |-> (ret_valid == 2'b00 && free_q == CW'(DEPTH)));
  // After a squash the tail sits right after the branch (R7).
  assert_squash_tail_R7: assert property (@(posedge clk) disable iff (rst)
    squash_young |-> tail_q == TAG_W'(wrap_add(32'($past(mis_tag)), 1, DEPTH)));
endmodule

// File: tb/tb_cq_order_buf.sv
module tb_cq_order_buf;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] claim_req;
  logic [2:0] slot_tag_a, slot_tag_b, free_slots;
  logic [1:0] done_valid;
  logic [5:0] done_tag;
  logic [1:0] done_fault;
  logic       mis_valid;
  logic [2:0] mis_tag;
  logic [1:0] ret_valid;
  logic [2:0] ret_tag_a, ret_tag_b, fault_tag;
  logic       fault_taken, squash_young;

  always #5 clk = ~clk;

  cq_order_buf dut (
    .clk(clk), .rst(rst), .claim_req(claim_req), .slot_tag_a(slot_tag_a),
    .slot_tag_b(slot_tag_b), .free_slots(free_slots), .done_valid(done_valid),
    .done_tag(done_tag), .done_fault(done_fault), .mis_valid(mis_valid),
    .mis_tag(mis_tag), .ret_valid(ret_valid), .ret_tag_a(ret_tag_a),
    .ret_tag_b(ret_tag_b), .fault_taken(fault_taken), .fault_tag(fault_tag),
    .squash_young(squash_young));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Reference model: program-ordered queue of tags.
  int q[$];
  bit mdone[6], mflt[6];
  int mtail;
  int e_rv0, e_rv1, e_rt0, e_rt1, e_exc, e_ext, e_sq;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic bit in_q(int t);
    foreach (q[k]) if (q[k] == t) return 1;
    return 0;
  endfunction

  task automatic model_step(int cr, int dv0, int dt0, int df0,
                            int dv1, int dt1, int df1, int mv, int mt);
    int sz, off, nret, nd;
    bit mp, r0, r1;
    sz = q.size();
    e_rv0 = 0; e_rv1 = 0; e_exc = 0; e_sq = 0;
    if (sz > 0 && mdone[q[0]] && mflt[q[0]]) begin
      e_exc = 1; e_ext = q[0];       // R6 / R9: exception wins
      q.delete();
      return;
    end
    mp = 0; off = 0;
    if (mv != 0) for (int k = 0; k < sz; k++) if (q[k] == mt) begin mp = 1; off = k; end
    r0 = (sz > 0) && mdone[q[0]];
    r1 = r0 && (sz > 1) && mdone[q[1]] && !mflt[q[1]] && !(mp && off == 0);
    if (r0) begin e_rv0 = 1; e_rt0 = q[0]; end
    if (r1) begin e_rv1 = 1; e_rt1 = q[1]; end
    nret = int'(r0) + int'(r1);
    if (mp) begin
      while (q.size() > off + 1) void'(q.pop_back());
      mtail = (mt + 1) % 6;
      e_sq = 1;
    end
    if (dv0 != 0 && in_q(dt0)) begin mdone[dt0] = 1; if (df0 != 0) mflt[dt0] = 1; end
    if (dv1 != 0 && in_q(dt1)) begin mdone[dt1] = 1; if (df1 != 0) mflt[dt1] = 1; end
    for (int k = 0; k < nret; k++) void'(q.pop_front());
    if (!mp) begin
      nd = (cr == 1) ? 1 : (cr == 3) ? 2 : 0;
      if (nd > 0 && nd <= 6 - sz)
        for (int k = 0; k < nd; k++) begin
          q.push_back(mtail); mdone[mtail] = 0; mflt[mtail] = 0;
          mtail = (mtail + 1) % 6;
        end
    end
  endtask

  task automatic compare_all();
    chk("R2 R6 R7 R8", "free_slots", int'(free_slots), 6 - q.size());
    chk("R1", "slot_tag_a", int'(slot_tag_a), mtail);
    chk("R1", "slot_tag_b", int'(slot_tag_b), (mtail + 1) % 6);
    chk("R3 R4 R5", "ret_valid0", int'(ret_valid[0]), e_rv0);
    chk("R5", "ret_valid1", int'(ret_valid[1]), e_rv1);
    if (e_rv0 != 0 && ret_valid[0]) chk("R4", "ret_tag_a", int'(ret_tag_a), e_rt0);
    if (e_rv1 != 0 && ret_valid[1]) chk("R5", "ret_tag_b", int'(ret_tag_b), e_rt1);
    chk("R6 R9", "fault_taken", int'(fault_taken), e_exc);
    if (e_exc != 0 && fault_taken) chk("R6", "fault_tag", int'(fault_tag), e_ext);
    chk("R7 R8 R9", "squash_young", int'(squash_young), e_sq);
  endtask

  initial begin
    int cr, dv0, dt0, df0, dv1, dt1, df1, mv, mt;
    rst = 1'b1; claim_req = '0; done_valid = '0; done_tag = '0;
    done_fault = '0; mis_valid = 1'b0; mis_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "reset free_slots", int'(free_slots), 6);
    chk("R10", "reset slot_tag_a", int'(slot_tag_a), 0);
    chk("R10", "reset ret_valid", int'(ret_valid), 0);
    chk("R10", "reset fault_taken", int'(fault_taken), 0);
    chk("R10", "reset squash_young", int'(squash_young), 0);
    q.delete(); mtail = 0;
    e_rv0 = 0; e_rv1 = 0; e_rt0 = 0; e_rt1 = 0; e_exc = 0; e_ext = 0; e_sq = 0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      if (cyc != 0) begin
        @(negedge clk);
        compare_all();
      end
      // Phases vary the pressure: heavy claims, heavy finishes, mixed.
      cr  = $urandom_range(0, 3);
      if ((cyc / 500) % 3 == 0 && $urandom_range(0, 3) != 0) cr = 3;
      dv0 = ($urandom_range(0, 9) < 5) ? 1 : 0;
      dv1 = ($urandom_range(0, 9) < ((cyc / 500) % 3 == 1 ? 7 : 3)) ? 1 : 0;
      dt0 = $urandom_range(0, 7);
      dt1 = (q.size() > 1 && $urandom_range(0, 1) == 1) ? q[1] : $urandom_range(0, 7);
      df0 = ($urandom_range(0, 24) == 0) ? 1 : 0;
      df1 = ($urandom_range(0, 24) == 0) ? 1 : 0;
      mv  = ($urandom_range(0, 15) == 0) ? 1 : 0;
      mt  = $urandom_range(0, 7);
      claim_req  = 2'(cr);
      done_valid = {1'(dv1), 1'(dv0)};
      done_tag   = {3'(dt1), 3'(dt0)};
      done_fault = {1'(df1), 1'(df0)};
      mis_valid  = 1'(mv);
      mis_tag    = 3'(mt);
      model_step(cr, dv0, dt0, df0, dv1, dt1, df1, mv, mt);
    end
    @(negedge clk);
    compare_all();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule